// File: doc/BRIEF.md
# Programmable Chip-Select Timing Generator

This block drives the strobes for one peripheral region on a processor bus. These are an active-low chip select, an active-low output enable, an active-low write enable and a read/write direction line. A request that falls inside a programmed address window starts a bus cycle. The strobes are then sequenced under a set of per-region timing options. The cycle is closed either by an internal wait-state counter, which then pulses transfer acknowledge, or by an acknowledge from the peripheral itself. When the region cannot take bursts, the block can flag burst inhibit alongside the acknowledge, so the master falls back to single transfers.

The block runs on a clock four times the bus clock. A free-running two-bit phase counter marks the bus clock boundaries: the bus edge is the fast edge at which the phase counter holds 3. Bus inputs are sampled only at bus edges. Strobe edges can sit on any fast edge, which gives quarter-bus-clock placement of chip-select assertion and half-clock early negation.

In the timing below, E0 is the bus edge at which a hitting request is accepted, and edge k is the k-th fast edge after E0. Every figure describes output values after that edge. S is the setup in fast edges: 4 for the relaxed option plus 4 for an extended-hold first access. A is the quarter delay: code 0 gives 0, code 1 gives 1, codes 2 and 3 give 2. E is the cycle end: S + 4·(wait+1) with internal termination.

Top module: `cs_timing_gen`

## Requirements
- R1: A request hits when addr_i and base_i agree on every bit at position size_i or above (a window of 2^size_i bytes). A miss starts no cycle, and every strobe stays inactive.
- R2: After reset and whenever no cycle runs, cs_n_o, oe_n_o and we_n_o are 1, ta_o and bi_o are 0, and rw_o is 1.
- R3: Chip select goes low after edge S + A and not earlier, where A is 0, 1 or 2 for cs_delay_i codes 0, 1 and 2 or 3.
- R4: With internal termination and early negation off, chip select stays low through edge E - 1 and returns high after edge E, for any wait_i from 0 to 15.
- R5: With early_neg_i set and internal termination, chip select and write enable return high after edge E - 2. Output enable still ends after edge E.
- R6: With relax_i set, S grows by 4 fast edges (one bus clock).
- R7: With first_hold_i set, S grows by 4 on a first access only. The first-access flag is 1 after reset, set by any idle bus edge or any missing request, and cleared when a hitting cycle starts.
- R8: Output enable is low only in read cycles and write enable only in write cycles, each from edge S + A. rw_o is 0 during a write cycle (through edge E - 1) and 1 otherwise.
- R9: With internal termination, ta_o is high after edges E - 4 to E - 1 (one bus clock) and low otherwise. With external termination, ta_o stays 0.
- R10: With external termination, the cycle ends at the first bus edge that sees ext_ack_i high once the count has reached S. Chip select is low until that edge, and early_neg_i has no effect.
- R11: With binh_i set, bi_o is high exactly while ta_o is high (internal) or while ext_ack_i is high within the strobe phase (external). With binh_i clear, bi_o stays 0.
- R12: All options and the wait count are captured when the cycle starts. Changing them during a cycle does not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, four times the bus clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| base_i | input | AW | Window base address |
| size_i | input | SZ_W | Window size as log2 of bytes |
| cs_delay_i | input | 2 | Chip-select quarter delay code |
| early_neg_i | input | 1 | Negate chip select and write enable half a bus clock early |
| relax_i | input | 1 | Add one bus clock of address setup |
| first_hold_i | input | 1 | Add one bus clock on a first access |
| wait_i | input | WAIT_W | Wait states for internal termination |
| ext_term_i | input | 1 | Peripheral ends the cycle with its acknowledge |
| binh_i | input | 1 | Flag burst inhibit with the acknowledge |
| req_i | input | 1 | Address valid, sampled at bus edges |
| addr_i | input | AW | Bus address |
| wr_i | input | 1 | 1 = write, 0 = read |
| ext_ack_i | input | 1 | Acknowledge from the peripheral |
| cs_n_o | output | 1 | Chip select, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| rw_o | output | 1 | Direction, 1 = read |
| ta_o | output | 1 | Transfer acknowledge from the wait counter |
| bi_o | output | 1 | Burst inhibit |

## Verification
The hardest state to reach from the ports is the first-access flag, because no output shows it. It can only be inferred from whether a cycle starts one bus clock late. The stimulus therefore builds a controlled history. It leaves an idle gap so that an idle bus edge sets the flag, then issues a hitting access with the extra bus clock expected. A hitting access follows back to back, with no idle bus edge between them, and must not get the extra bus clock. A missing request is then issued, and the hit right after it must again be treated as first. External termination is likewise phase-sensitive: the bench raises the acknowledge for exactly the bus clock whose closing edge should end the cycle, and checks burst inhibit while that acknowledge is high.

// File: rtl/csg_pkg.sv
package csg_pkg;

   localparam int QPB = 4;   // fast edges per bus clock

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } csg_state_e;

   typedef struct packed {
      logic [1:0] delay;
      logic       early;
      logic       relax;
      logic       hold;
      logic       ext;
      logic       binh;
   } csg_opts_t;

   function automatic logic [1:0] delay_quarters(input logic [1:0] code);
      case (code)
         2'd0:    delay_quarters = 2'd0;
         2'd1:    delay_quarters = 2'd1;
         default: delay_quarters = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/csg_phase.sv
module csg_phase #(
   parameter int PH_W = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic bus_edge_o
);
   localparam logic [PH_W-1:0] PH_LAST = '1;

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) ph_q <= '0;
      else         ph_q <= ph_q + 1'b1;
   end

   assign bus_edge_o = (ph_q == PH_LAST);
endmodule

// File: rtl/csg_window.sv
module csg_window #(
   parameter int AW   = 16,
   parameter int SZ_W = 5
) (
   input  logic [AW-1:0]   base_i,
   input  logic [SZ_W-1:0] size_i,
   input  logic [AW-1:0]   addr_i,
   output logic            hit_o
);
   logic [AW-1:0] bit_ok;

   for (genvar i = 0; i < AW; i++) begin : g_bit
      // bits below the window size are don't-care
      assign bit_ok[i] = (SZ_W'(i) < size_i) || (addr_i[i] == base_i[i]);
   end

   assign hit_o = &bit_ok;
endmodule

// File: rtl/csg_first.sv
module csg_first (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bus_edge_i,
   input  logic idle_i,
   input  logic req_i,
   input  logic hit_i,
   output logic first_o
);
   logic first_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                 first_q <= 1'b1;
      else if (bus_edge_i && idle_i) first_q <= !(req_i && hit_i);
   end

   assign first_o = first_q;
endmodule

// File: rtl/csg_seq.sv
module csg_seq
   import csg_pkg::*;
#(
   parameter int WAIT_W = 4,
   parameter int CNT_W  = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_edge_i,
   input  logic              req_hit_i,
   input  logic              first_i,
   input  logic              wr_i,
   input  logic              ext_ack_i,
   input  csg_opts_t         opts_i,
   input  logic [WAIT_W-1:0] wait_i,
   output logic              idle_o,
   output logic              ext_active_o,
   output logic              cs_n_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   output logic              rw_o,
   output logic              ta_o,
   output logic              bi_o
);
   localparam logic [CNT_W-1:0] ONE_BC = CNT_W'(QPB);
   localparam logic [CNT_W-1:0] HALF_BC = CNT_W'(QPB / 2);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   csg_state_e       state_q;
   csg_opts_t        opts_q;
   logic             wr_q;
   logic [CNT_W-1:0] t_q, setup_q, csb_q, end_q;
   logic [CNT_W-1:0] setup_d, csb_d, end_d;
   logic             run, start, int_done, ext_done;
   logic             strobe_on, oe_on, cut_early, in_strobe;

   // thresholds for the cycle, computed from the live options at start
   always_comb begin
      setup_d = '0;
      if (opts_i.relax)             setup_d = setup_d + ONE_BC;
      if (opts_i.hold && first_i)   setup_d = setup_d + ONE_BC;
      csb_d = setup_d + CNT_W'(delay_quarters(opts_i.delay));
      end_d = setup_d + ONE_BC * (CNT_W'(wait_i) + CNT_W'(1));
   end

   assign run      = (state_q == ST_RUN);
   assign start    = bus_edge_i && req_hit_i && !run;
   assign in_strobe = (t_q >= setup_q);
   assign int_done = run && !opts_q.ext && (t_q == end_q - CNT_W'(1));
   assign ext_done = run && opts_q.ext && bus_edge_i && ext_ack_i && in_strobe;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         opts_q  <= '0;
         wr_q    <= 1'b0;
         t_q     <= '0;
         setup_q <= '0;
         csb_q   <= '0;
         end_q   <= '0;
      end else if (start) begin
         state_q <= ST_RUN;
         opts_q  <= opts_i;
         wr_q    <= wr_i;
         t_q     <= '0;
         setup_q <= setup_d;
         csb_q   <= csb_d;
         end_q   <= end_d;
      end else if (run) begin
         if (int_done || ext_done) state_q <= ST_IDLE;
         else if (t_q != CNT_MAX)  t_q <= t_q + CNT_W'(1);
      end
   end

   assign strobe_on = run && (t_q >= csb_q) && (opts_q.ext || (t_q < end_q));
   assign oe_on     = strobe_on && !wr_q;
   assign cut_early = !opts_q.ext && opts_q.early && (t_q >= end_q - HALF_BC);

   assign cs_n_o = !(strobe_on && !cut_early);
   assign we_n_o = !(strobe_on && !cut_early && wr_q);
   assign oe_n_o = !oe_on;
   assign rw_o   = !(run && wr_q);
   assign ta_o   = run && !opts_q.ext && (t_q >= end_q - ONE_BC);
   assign bi_o   = run && opts_q.binh &&
                   (ta_o || (opts_q.ext && ext_ack_i && in_strobe));

   assign idle_o       = !run;
   assign ext_active_o = run && opts_q.ext;
endmodule

// File: rtl/cs_timing_gen.sv
module cs_timing_gen
   import csg_pkg::*;
#(
   parameter int AW     = 16,
   parameter int WAIT_W = 4,
   parameter int SZ_W   = $clog2(AW + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [AW-1:0]     base_i,
   input  logic [SZ_W-1:0]   size_i,
   input  logic [1:0]        cs_delay_i,
   input  logic              early_neg_i,
   input  logic              relax_i,
   input  logic              first_hold_i,
   input  logic [WAIT_W-1:0] wait_i,
   input  logic              ext_term_i,
   input  logic              binh_i,
   input  logic              req_i,
   input  logic [AW-1:0]     addr_i,
   input  logic              wr_i,
   input  logic              ext_ack_i,
   output logic              cs_n_o,
   output logic              oe_n_o,
   output logic              we_n_o,
   output logic              rw_o,
   output logic              ta_o,
   output logic              bi_o
);
   // two setup bus clocks plus the longest strobe phase
   localparam int MAX_T = 2 * QPB + QPB * (2 ** WAIT_W);
   localparam int CNT_W = $clog2(MAX_T + 1);

   if (AW < 4) begin : g_bad_aw
      $error("cs_timing_gen: AW must be at least 4");
   end
   if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
      $error("cs_timing_gen: WAIT_W must be 1..8");
   end
   if ((1 << SZ_W) <= AW) begin : g_bad_sz
      $error("cs_timing_gen: SZ_W too narrow for AW");
   end

   logic      bus_edge, hit, first, idle, cyc_ext;
   csg_opts_t opts;

   assign opts = '{delay: cs_delay_i, early: early_neg_i, relax: relax_i,
                   hold: first_hold_i, ext: ext_term_i, binh: binh_i};

   csg_phase #(.PH_W(2)) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bus_edge_o (bus_edge)
   );

   csg_window #(.AW(AW), .SZ_W(SZ_W)) u_window (
      .base_i (base_i),
      .size_i (size_i),
      .addr_i (addr_i),
      .hit_o  (hit)
   );

   csg_first u_first (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .bus_edge_i (bus_edge),
      .idle_i     (idle),
      .req_i      (req_i),
      .hit_i      (hit),
      .first_o    (first)
   );

   csg_seq #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_seq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .bus_edge_i   (bus_edge),
      .req_hit_i    (req_i && hit),
      .first_i      (first),
      .wr_i         (wr_i),
      .ext_ack_i    (ext_ack_i),
      .opts_i       (opts),
      .wait_i       (wait_i),
      .idle_o       (idle),
      .ext_active_o (cyc_ext),
      .cs_n_o       (cs_n_o),
      .oe_n_o       (oe_n_o),
      .we_n_o       (we_n_o),
      .rw_o         (rw_o),
      .ta_o         (ta_o),
      .bi_o         (bi_o)
   );
endmodule

// File: rtl/csg_checker.sv
module csg_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic cs_n,
   input logic oe_n,
   input logic we_n,
   input logic rw,
   input logic ta,
   input logic bi,
   input logic ext_ack,
   input logic cyc_ext
);
   // R8: read and write strobes never overlap
   p_oe_we_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(!oe_n && !we_n));

   // R8: write enable only inside chip select
   p_we_in_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_n |-> !cs_n);

   // R8: strobe matches direction line
   p_oe_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_n |-> rw);
   p_we_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_n |-> !rw);

   // R8: direction does not move while chip select is held
   p_rw_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_n && $past(!cs_n)) |-> $stable(rw));

   // R9: acknowledge lasts exactly one bus clock
   p_ta_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ta) |=> ta ##1 ta ##1 ta ##1 !ta);

   // R9: no internal acknowledge in an externally terminated cycle
   p_ta_ext_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cyc_ext |-> !ta);

   // R11: burst inhibit only together with an acknowledge
   p_bi_ack_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bi |-> (ta || ext_ack));
endmodule

bind cs_timing_gen csg_checker u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .cs_n    (cs_n_o),
   .oe_n    (oe_n_o),
   .we_n    (we_n_o),
   .rw      (rw_o),
   .ta      (ta_o),
   .bi      (bi_o),
   .ext_ack (ext_ack_i),
   .cyc_ext (cyc_ext)
);

// File: tb/tb_cs_timing_gen.sv
module tb_cs_timing_gen;
   localparam int AW = 16;
   localparam int WAIT_W = 4;
   localparam int SZ_W = $clog2(AW + 1);
   localparam int WIN = 12;
   localparam logic [AW-1:0] BASE = 16'h4000;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic              rst_n = 1'b0;
   logic [1:0]        cs_delay = '0;
   logic              early = 0, relax = 0, hold = 0, ext = 0, binh = 0;
   logic [WAIT_W-1:0] waits = '0;
   logic              req = 0, wr = 0, ack = 0;
   logic [AW-1:0]     addr = '0;
   logic              cs_n, oe_n, we_n, rw, ta, bi;

   int n_chk = 0, n_fail = 0, tk = 0;
   bit done = 0;

   always @(posedge clk) if (rst_n) tk <= tk + 1;

   cs_timing_gen dut (
      .clk_i(clk), .rst_ni(rst_n), .base_i(BASE), .size_i(SZ_W'(WIN)),
      .cs_delay_i(cs_delay), .early_neg_i(early), .relax_i(relax),
      .first_hold_i(hold), .wait_i(waits), .ext_term_i(ext), .binh_i(binh),
      .req_i(req), .addr_i(addr), .wr_i(wr), .ext_ack_i(ack),
      .cs_n_o(cs_n), .oe_n_o(oe_n), .we_n_o(we_n), .rw_o(rw),
      .ta_o(ta), .bi_o(bi));

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // one bus access; traces all outputs per fast edge against the timing rules
   task automatic access(input string rq, input logic [AW-1:0] a, input bit w,
                         input int dly, input bit e, input bit rl, input bit hd,
                         input bit x, input bit bn, input int nw, input bit first,
                         input int ackm, input bit midchg);
      string nm[6] = '{"cs_n", "oe_n", "we_n", "ta", "bi", "rw"};
      bit hit, ackv;
      int qa, s, en, csend, n;
      int bad_k[6], bad_a[6], bad_e[6];
      bit [5:0] act, exp;
      hit = (a[AW-1:WIN] == BASE[AW-1:WIN]);
      qa = (dly >= 2) ? 2 : dly;
      s = 4 * (int'(rl) + int'(hd && first));
      en = x ? s + 4 * ackm : s + 4 * (nw + 1);
      csend = (!x && e) ? en - 2 : en;
      n = hit ? en + 4 : 12;
      for (int i = 0; i < 6; i++) bad_k[i] = -1;
      cs_delay = dly[1:0]; early = e; relax = rl; hold = hd; ext = x;
      binh = bn; waits = nw[WAIT_W-1:0]; addr = a; wr = w; ackv = 0; ack = 0;
      while (tk % 4 != 3) @(negedge clk);
      req = 1;
      @(posedge clk);
      for (int k = 0; k < n; k++) begin
         if (k > 0) @(posedge clk);
         @(negedge clk);
         if (k == 0) req = 0;
         exp[0] = !(hit && k >= s + qa && k < csend);
         exp[1] = !(hit && !w && k >= s + qa && k < en);
         exp[2] = !(hit && w && k >= s + qa && k < csend);
         exp[3] = hit && !x && k >= en - 4 && k < en;
         exp[4] = bn && hit && (exp[3] || (x && ackv && k >= s && k < en));
         exp[5] = !(hit && w && k < en);
         act = {rw, bi, ta, we_n, oe_n, cs_n};
         for (int i = 0; i < 6; i++)
            if (act[i] != exp[i] && bad_k[i] < 0) begin
               bad_k[i] = k; bad_a[i] = act[i]; bad_e[i] = exp[i];
            end
         if (midchg && k == 1) begin   // R12: disturb every option mid-cycle
            cs_delay = ~cs_delay; early = ~early; relax = ~relax;
            hold = ~hold; ext = ~ext; binh = ~binh; waits = ~waits; wr = ~wr;
         end
         ackv = x && hit && k >= en - 4 && k < en;
         ack = ackv;
      end
      ack = 0;
      for (int i = 0; i < 6; i++)
         check(bad_k[i] < 0, rq, $sformatf("%s at edge %0d", nm[i], bad_k[i]),
               bad_a[i], bad_e[i]);
   endtask

   task automatic t_reset;   // R2
      check(cs_n == 1, "R2", "cs_n after reset", cs_n, 1);
      check(oe_n == 1, "R2", "oe_n after reset", oe_n, 1);
      check(we_n == 1, "R2", "we_n after reset", we_n, 1);
      check(ta == 0, "R2", "ta after reset", ta, 0);
      check(bi == 0, "R2", "bi after reset", bi, 0);
      check(rw == 1, "R2", "rw after reset", rw, 1);
   endtask

   task automatic t_basic;   // R4 R8 R9
      access("R4/R8/R9 read", 16'h4010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      access("R4/R8/R9 write", 16'h4020, 1, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0);
   endtask

   task automatic t_quarter;   // R3
      access("R3 delay1", 16'h4100, 1, 1, 0, 0, 0, 0, 0, 2, 0, 0, 0);
      access("R3 delay2", 16'h4104, 0, 2, 0, 0, 0, 0, 0, 2, 0, 0, 0);
      access("R3 delay3", 16'h4108, 1, 3, 0, 0, 0, 0, 0, 2, 0, 0, 0);
   endtask

   task automatic t_early;   // R5
      access("R5 write", 16'h4200, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
      access("R5 read", 16'h4204, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_relax;   // R6
      access("R6 relaxed", 16'h4300, 0, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0);
   endtask

   task automatic t_first;   // R7
      repeat (8) @(negedge clk);
      access("R7 first after idle", 16'h4400, 1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
      access("R7 back to back", 16'h4404, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      access("R7 miss", 16'h8000, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      access("R7 first after miss", 16'h4408, 0, 1, 0, 1, 1, 0, 0, 1, 1, 0, 0);
   endtask

   task automatic t_window;   // R1
      access("R1 top of window", 16'h4FFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      access("R1 below window", 16'h3FFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      access("R1 above window", 16'h5000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      access("R1 base", 16'h4000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_ext;   // R10 R11 R9
      access("R10/R11/R9 ext read", 16'h4500, 0, 1, 1, 0, 0, 1, 1, 0, 0, 3, 0);
      access("R10/R9 ext write", 16'h4504, 1, 2, 0, 1, 0, 1, 0, 7, 0, 1, 0);
   endtask

   task automatic t_binh;   // R11
      access("R11 inhibit", 16'h4600, 1, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0);
   endtask

   task automatic t_long;   // R4
      access("R4 max waits", 16'h4700, 0, 2, 0, 0, 0, 0, 0, 15, 0, 0, 0);
   endtask

   task automatic t_capture;   // R12
      access("R12 options held", 16'h4800, 1, 1, 0, 0, 0, 0, 0, 2, 0, 0, 1);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_basic();
      t_quarter();
      t_early();
      t_relax();
      t_first();
      t_window();
      t_ext();
      t_binh();
      t_long();
      t_capture();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule